// File: doc/BRIEF.md
# Timer Compare Cell with Edge-Triggered Shadow Reload

This block is one compare cell of a larger timer array. Every clock it compares a shared timer value bus against its own compare register. A control bit can reverse the bit order of the bus before the comparison. Each match produces a one-cycle compare event. Each compare event also flips a read-only output-state flag.

A second register, the shadow, holds the next compare value. The shadow is copied into the compare register when a chosen edge appears on a dedicated trigger line. The edge can be rising, falling or either. The trigger line is synchronised into the clock domain before its edges are detected. A one-shot option limits copying to a single copy per arming. Writing the control or shadow register arms the cell again.

A two-bit request selector sends a one-cycle service-request pulse on compare events, on copy events, or on neither. Software reaches the control, compare and shadow values through a simple synchronous write port and a combinational read port.

Top module: `cmp_shadow_cell`

## Requirements
- R1: After a synchronous reset, the control, compare and shadow registers read as zero, and `cmp_evt`, `copy_evt` and `srq` are low.
- R2: With control bit 6 (enable) set and bit 0 clear, `cmp_evt` is high in the cycle after each clock cycle in which `tmr_bus` equals the compare register, and low otherwise.
- R3: With control bit 0 set, the comparison uses the reversed bus (bus bit i moved to position TW-1-i) in place of the bus.
- R4: With control bit 6 clear, `cmp_evt` never rises, whatever the bus value.
- R5: Control bits [3:2] select the request. 00 gives no request, 01 pulses `srq` together with `cmp_evt`, 10 pulses `srq` together with `copy_evt`, and 11 gives no request.
- R6: With control bit 4 set, a rising edge on `line_in` copies the shadow into the compare register. The copy is visible at the third clock edge after the line changes.
- R7: With control bit 5 set, a falling edge on `line_in` causes the copy. With both bits 4 and 5 set, either edge causes it. With neither set, no edge causes a copy.
- R8: With control bit 1 (one-shot) set, only the first qualifying edge after arming copies. A write to the control register or the shadow register arms the cell again.
- R9: Control readback holds writable bits 0 to 7, where bit 7 is a stored level-mode flag. Bit 8 is a read-only output state that toggles on every compare event and ignores writes. All other bits read zero.
- R10: Every copy raises `copy_evt` for exactly the cycle in which the new compare value first appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_bus | input | TW | Shared timer value |
| line_in | input | 1 | Asynchronous trigger line for the shadow copy |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 compare, 2 shadow |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| cmp_evt | output | 1 | Compare event pulse |
| copy_evt | output | 1 | Shadow copy pulse |
| srq | output | 1 | Service request pulse |

## Verification
The bench sweeps every 8-bit bus value against compare values at both ends of the range and in the middle, once in normal order and once reversed. A mistake in the reversal or in the equality test therefore shows up as a missing match or an extra match. The same sweep with the enable clear shows that the enable gates events. Each edge-select combination is driven with both line directions, so a swapped edge or a missing copy shows up in the compare readback and in the `copy_evt` timing. One-shot runs send repeated edges and then re-arm through each of the two register writes. All four request codes are driven through one compare event and one copy event each, which separates a request routed to the wrong source from a request that is missing.

// File: rtl/cmp_cell_pkg.sv
package cmp_cell_pkg;

    typedef enum logic [1:0] {
        REQ_OFF  = 2'b00,
        REQ_CMP  = 2'b01,
        REQ_COPY = 2'b10,
        REQ_RSV  = 2'b11
    } req_sel_e;

    // Writable control bits, MSB first: bit 7 down to bit 0
    typedef struct packed {
        logic     lvl;   // bit 7: stored level-mode flag
        logic     en;    // bit 6: cell enable
        logic     fed;   // bit 5: copy on falling edge
        logic     red;   // bit 4: copy on rising edge
        req_sel_e ren;   // bits 3:2: request select
        logic     osm;   // bit 1: one-shot copy
        logic     brm;   // bit 0: reversed compare
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);
    localparam int OUT_BIT   = 8;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CMP  = 2'd1;
    localparam logic [1:0] A_SHD  = 2'd2;

    function automatic logic req_fire(req_sel_e sel, logic hit, logic copy);
        case (sel)
            REQ_CMP:  return hit;
            REQ_COPY: return copy;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cmp_cell_edge.sv
module cmp_cell_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/cmp_cell_match.sv
module cmp_cell_match #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] bus,
    input  logic [TW-1:0] cmp_q,
    input  logic          brm,
    input  logic          en,
    output logic          hit,
    output logic          evt
);
    logic [TW-1:0] bus_rev;
    logic [TW-1:0] bus_sel;

    for (genvar i = 0; i < TW; i++) begin : g_rev
        assign bus_rev[i] = bus[TW-1-i];
    end

    assign bus_sel = brm ? bus_rev : bus;
    assign hit     = en && (bus_sel == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) evt <= 1'b0;
        else     evt <= hit;
    end
endmodule

// File: rtl/cmp_cell_regs.sv
module cmp_cell_regs
    import cmp_cell_pkg::*;
#(
    parameter int TW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          rise,
    input  logic          fall,
    input  logic          hit,
    output ctrl_t         ctrl_q,
    output logic [TW-1:0] cmp_q,
    output logic [TW-1:0] shd_q,
    output logic          armed_q,
    output logic          out_q,
    output logic          copy_now,
    output logic          copy_evt
);
    logic edge_ok;

    assign edge_ok  = (ctrl_q.red & rise) | (ctrl_q.fed & fall);
    assign copy_now = edge_ok & (~ctrl_q.osm | armed_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cmp_q    <= '0;
            shd_q    <= '0;
            armed_q  <= 1'b1;
            out_q    <= 1'b0;
            copy_evt <= 1'b0;
        end else begin
            copy_evt <= copy_now;
            if (hit) out_q <= ~out_q;
            if (copy_now) begin
                cmp_q <= shd_q;
                if (ctrl_q.osm) armed_q <= 1'b0;
            end
            if (we) begin
                case (addr)
                    A_CTRL: begin
                        ctrl_q  <= ctrl_t'(wdata[CTRL_BITS-1:0]);
                        armed_q <= 1'b1;
                    end
                    A_CMP: cmp_q <= wdata[TW-1:0];
                    A_SHD: begin
                        shd_q   <= wdata[TW-1:0];
                        armed_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CTRL_BITS-1:0] = ctrl_q;
                rdata[OUT_BIT]       = out_q;
            end
            A_CMP:   rdata[TW-1:0] = cmp_q;
            A_SHD:   rdata[TW-1:0] = shd_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmp_shadow_cell.sv
module cmp_shadow_cell
    import cmp_cell_pkg::*;
#(
    parameter int TW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tmr_bus,
    input  logic          line_in,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          cmp_evt,
    output logic          copy_evt,
    output logic          srq
);
    ctrl_t         ctrl_q;
    logic [TW-1:0] cmp_q;
    logic [TW-1:0] shd_q;
    logic          armed_q;
    logic          out_q;
    logic          rise;
    logic          fall;
    logic          hit;
    logic          copy_now;

    cmp_cell_edge #(.SYNC_STAGES(2)) u_edge (
        .clk(clk), .rst(rst), .line_in(line_in), .rise(rise), .fall(fall)
    );

    cmp_cell_match #(.TW(TW)) u_match (
        .clk(clk), .rst(rst), .bus(tmr_bus), .cmp_q(cmp_q),
        .brm(ctrl_q.brm), .en(ctrl_q.en), .hit(hit), .evt(cmp_evt)
    );

    cmp_cell_regs #(.TW(TW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .rise(rise), .fall(fall),
        .hit(hit), .ctrl_q(ctrl_q), .cmp_q(cmp_q), .shd_q(shd_q),
        .armed_q(armed_q), .out_q(out_q), .copy_now(copy_now),
        .copy_evt(copy_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) srq <= 1'b0;
        else     srq <= req_fire(ctrl_q.ren, hit, copy_now);
    end
endmodule

// File: rtl/cmp_cell_checker.sv
module cmp_cell_checker
    import cmp_cell_pkg::*;
#(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [TW-1:0] bus,
    input ctrl_t         ctrl,
    input logic [TW-1:0] cmp_q,
    input logic [TW-1:0] shd_q,
    input logic          armed,
    input logic          out_q,
    input logic          cmp_evt,
    input logic          copy_evt,
    input logic          srq,
    input logic          reg_we,
    input logic [1:0]    reg_addr
);
    logic [TW-1:0] rev;
    logic [TW-1:0] sel;

    for (genvar i = 0; i < TW; i++) begin : g_r
        assign rev[i] = bus[TW-1-i];
    end
    assign sel = ctrl.brm ? rev : bus;

    p_match_r2: assert property (@(posedge clk) disable iff (rst)
        cmp_evt |-> ($past(sel) == $past(cmp_q)));

    p_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        cmp_evt |-> $past(ctrl.en));

    p_srq_src_r5: assert property (@(posedge clk) disable iff (rst)
        srq |-> ((cmp_evt && $past(ctrl.ren) == REQ_CMP) ||
                 (copy_evt && $past(ctrl.ren) == REQ_COPY)));

    p_copy_load_r6: assert property (@(posedge clk) disable iff (rst)
        (copy_evt && !$past(reg_we && reg_addr == A_CMP)) |-> (cmp_q == $past(shd_q)));

    p_oneshot_r8: assert property (@(posedge clk) disable iff (rst)
        (copy_evt && $past(ctrl.osm) && !$past(reg_we)) |-> !armed);

    p_out_toggle_r9: assert property (@(posedge clk) disable iff (rst)
        cmp_evt |-> (out_q != $past(out_q)));
endmodule

bind cmp_shadow_cell cmp_cell_checker #(.TW(TW)) u_chk (
    .clk(clk), .rst(rst), .bus(tmr_bus), .ctrl(ctrl_q), .cmp_q(cmp_q),
    .shd_q(shd_q), .armed(armed_q), .out_q(out_q), .cmp_evt(cmp_evt),
    .copy_evt(copy_evt), .srq(srq), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/cmp_shadow_cell_test.sv
`timescale 1ns/1ps
module cmp_shadow_cell_test;
    localparam int TW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] tmr_bus = '0;
    logic          line_in = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          cmp_evt, copy_evt, srq;

    int n_tests = 0;
    int n_fail  = 0;
    int n_evt   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    cmp_shadow_cell #(.TW(TW), .DW(DW)) uut (
        .clk(clk), .rst(rst), .tmr_bus(tmr_bus), .line_in(line_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmp_evt(cmp_evt), .copy_evt(copy_evt), .srq(srq)
    );

    always @(negedge clk) if (!rst && cmp_evt) n_evt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] flip(input logic [TW-1:0] v);
        logic [TW-1:0] r;
        for (int i = 0; i < TW; i++) r[i] = v[TW-1-i];
        return r;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Drive line to level v; check copy pulse timing and compare readback
    task automatic drive_line(input string req, input logic v, input bit exp_copy,
                              input logic [31:0] exp_cmp);
        logic [31:0] d;
        @(negedge clk);
        line_in = v;
        repeat (2) @(negedge clk);
        chk(req, {31'd0, copy_evt}, 32'd0);
        @(negedge clk);
        chk(req, {31'd0, copy_evt}, {31'd0, exp_copy});
        rd(2'd1, d);
        chk(req, d, exp_cmp);
        @(negedge clk);
        chk(req, {31'd0, copy_evt}, 32'd0);
    endtask

    task automatic sweep(input string req, input logic [31:0] ctrl, input logic [TW-1:0] cval);
        wr(2'd0, ctrl);
        wr(2'd1, {24'd0, cval});
        for (int v = 0; v < 256; v++) begin
            logic [TW-1:0] b;
            bit e;
            b = v[TW-1:0];
            e = ctrl[6] && ((ctrl[0] ? flip(b) : b) == cval);
            @(negedge clk);
            tmr_bus = b;
            @(negedge clk);
            chk(req, {31'd0, cmp_evt}, {31'd0, e});
            chk(req, {31'd0, srq}, {31'd0, e});
        end
        @(negedge clk);
        tmr_bus = 8'hEE;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd(2'd0, d); chk("R1", d, 32'd0);
        rd(2'd1, d); chk("R1", d, 32'd0);
        rd(2'd2, d); chk("R1", d, 32'd0);
        chk("R1", {29'd0, cmp_evt, copy_evt, srq}, 32'd0);

        // R2 normal order (en, req=cmp), R3 reversed, R4 disabled
        sweep("R2", 32'h44, 8'h35);
        sweep("R2", 32'h44, 8'h00);
        sweep("R2", 32'h44, 8'hFF);
        sweep("R3", 32'h45, 8'h35);
        sweep("R3", 32'h45, 8'h01);
        sweep("R3", 32'h45, 8'hC8);
        sweep("R4", 32'h04, 8'h35);

        // R9: out bit tracks event parity, writable mask, read-only out bit
        rd(2'd0, d); chk("R9", d[8], n_evt[0]);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); chk("R9", d & 32'hFFFF_FEFF, 32'h0000_00FF);
        chk("R9", d[8], n_evt[0]);
        wr(2'd0, 32'h0);
        tmr_bus = 8'hEE;
        @(negedge clk);

        // R6 rising, R7 falling / both / none, R10 pulse timing
        wr(2'd0, 32'h50);
        wr(2'd2, 32'hA1); drive_line("R6", 1'b1, 1'b1, 32'hA1);
        wr(2'd2, 32'hB2); drive_line("R6", 1'b0, 1'b0, 32'hA1);
        wr(2'd0, 32'h60);
        wr(2'd2, 32'hC3); drive_line("R7", 1'b1, 1'b0, 32'hA1);
        drive_line("R7", 1'b0, 1'b1, 32'hC3);
        wr(2'd0, 32'h70);
        wr(2'd2, 32'h11); drive_line("R7", 1'b1, 1'b1, 32'h11);
        wr(2'd2, 32'h22); drive_line("R10", 1'b0, 1'b1, 32'h22);
        wr(2'd0, 32'h40);
        wr(2'd2, 32'h33); drive_line("R7", 1'b1, 1'b0, 32'h22);
        drive_line("R7", 1'b0, 1'b0, 32'h22);

        // R8: one-shot, re-arm by shadow write then by control write
        wr(2'd0, 32'h52);
        wr(2'd2, 32'h44); drive_line("R8", 1'b1, 1'b1, 32'h44);
        drive_line("R8", 1'b0, 1'b0, 32'h44);
        drive_line("R8", 1'b1, 1'b0, 32'h44);
        drive_line("R8", 1'b0, 1'b0, 32'h44);
        wr(2'd2, 32'h55); drive_line("R8", 1'b1, 1'b1, 32'h55);
        drive_line("R8", 1'b0, 1'b0, 32'h55);
        wr(2'd1, 32'h01); wr(2'd0, 32'h52);
        drive_line("R8", 1'b1, 1'b1, 32'h55);

        // R5: all request codes on a compare event and on a copy event
        drive_line("R5", 1'b0, 1'b0, 32'h55);
        for (int c = 0; c < 4; c++) begin
            logic [31:0] cw;
            cw = 32'h50 | (c << 2);
            tmr_bus = 8'h00;
            wr(2'd0, cw);
            wr(2'd1, 32'h10);
            @(negedge clk); tmr_bus = 8'h10;
            @(negedge clk);
            chk("R5", {31'd0, cmp_evt}, 32'd1);
            chk("R5", {31'd0, srq}, {31'd0, c == 1});
            tmr_bus = 8'h00;
            wr(2'd2, 32'h20);
            @(negedge clk); line_in = 1'b1;
            repeat (3) @(negedge clk);
            chk("R5", {31'd0, copy_evt}, 32'd1);
            chk("R5", {31'd0, srq}, {31'd0, c == 2});
            @(negedge clk); line_in = 1'b0;
            repeat (4) @(negedge clk);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule